// File: doc/BRIEF.md
# PLL Divider Search Engine

This block chooses PLL settings for a clock subsystem. Given a reference frequency and two wanted output clocks (a core clock and a microcontroller clock), it walks through the possible PLL feedback multipliers and returns the first one that lets both clocks be made by integer division of the PLL output. It also returns the two divisors and a packed loop-filter word for the multiplier it picked. The loop-filter word comes from an internal lookup.

All arithmetic is done in kHz. The reference is given as whole MHz plus a kHz remainder. The targets are whole MHz. A one-cycle start request begins a search. One shared restoring divider is used for both divisions, so each candidate takes a few tens of cycles. The result comes with a one-cycle done pulse and stays on the outputs until the next search finishes. The block flags an error when the request is invalid or when no candidate is acceptable.

Top module: `pll_div_search`

## Requirements
- R1: After synchronous reset, `done`, `err`, `fb_sel`, `core_div`, `mcu_div` and `cfg_word` are all zero.
- R2: The candidate multipliers are 25 to 125. They are tried from 125 downward, and the first acceptable one is reported in `fb_sel`.
- R3: The reference in kHz is `ref_mhz*1000 + ref_khz_frac`. The VCO value is the multiplier times the reference. A candidate is skipped if the VCO value is below 1500000 kHz, above 3000000 kHz, or odd; both limits are inclusive. The PLL output is half the VCO value.
- R4: The core divisor is the truncated quotient of the PLL output by the core target. It is accepted when the remainder is zero, or when the target minus the remainder is strictly below 10000 kHz. The quotient must also lie between 1 and 63.
- R5: The microcontroller divisor is the truncated quotient of the PLL output by its target. It is accepted only when the target minus the remainder is strictly below 10000 kHz, so an exact division with a target of 10 MHz or more is rejected. The quotient must also lie between 1 and 63.
- R6: A zero core target, a zero microcontroller target, or an `out_div_sel` value other than 1 ends the search at once with `err`=1. In that case `fb_sel`, `core_div`, `mcu_div` and `cfg_word` are zero.
- R7: When no multiplier down to 25 is acceptable, the search ends with `err`=1 and all result fields zero.
- R8: On success, `cfg_word` holds the resistor code in bits 3:0, the charge-pump code in bits 8:5, the value 3 in bits 11:10, the lock count in bits 22:13 and the value 63 in bits 31:25. All other bits are zero.
- R9: Each accepted start produces exactly one `done` pulse, and `done` is never high for two cycles in a row.
- R10: A start request while a search is in progress is ignored. This includes the cycle in which the result is being written.
- R11: The result outputs change only in the cycle where `done` is high, and hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (sampled only when idle) |
| ref_mhz | input | REF_INT_W | Reference frequency, whole MHz |
| ref_khz_frac | input | REF_FRAC_W | Reference frequency, extra kHz |
| core_mhz | input | TGT_W | Core clock target in MHz |
| mcu_mhz | input | TGT_W | Microcontroller clock target in MHz |
| out_div_sel | input | ODIV_W | External output-divider field, must be 1 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Search failed or request invalid |
| fb_sel | output | 7 | Chosen feedback multiplier |
| core_div | output | 6 | Core clock divisor |
| mcu_div | output | 6 | Microcontroller clock divisor |
| cfg_word | output | 32 | Packed loop-filter configuration |

## Verification
A start request and the delivery of a result can fall in the same cycle, because the bench may keep `start` high while a search finishes. The bench provokes this in two ways. It holds `start` over the whole of a long search, and it holds `start` for two cycles on a request that fails at once, so that the second request meets the result-write cycle. In both cases the bench expects exactly one `done` pulse, and the values it carries must match the first request. Any extra pulse, or any output change outside a pulse, is reported against the behavioural model.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int FB_W   = 7;
  localparam int DIVR_W = 6;
  localparam int CFG_W  = 32;

  localparam int unsigned FB_LO      = 25;
  localparam int unsigned FB_HI      = 125;
  localparam int unsigned VCO_LO_KHZ = 1500000;
  localparam int unsigned VCO_HI_KHZ = 3000000;
  localparam int unsigned TOL_KHZ    = 10000;
  localparam int unsigned DIVR_MIN   = 1;
  localparam int unsigned DIVR_MAX   = 63;

  typedef enum logic [2:0] {
    S_IDLE, S_VCO, S_CORE, S_MCU, S_NEXT, S_DONE
  } state_t;

  typedef struct packed {
    logic [3:0] res;
    logic [3:0] pump;
    logic [1:0] hf;
    logic [9:0] lock_cnt;
    logic [6:0] lock_dly;
  } filt_t;

  function automatic logic [CFG_W-1:0] pack_cfg(filt_t f);
    logic [CFG_W-1:0] w;
    w = '0;
    w[3:0]   = f.res;
    w[8:5]   = f.pump;
    w[11:10] = f.hf;
    w[22:13] = f.lock_cnt;
    w[31:25] = f.lock_dly;
    return w;
  endfunction

  // Loop-filter settings per multiplier, given as ranges.
  function automatic filt_t filt_for(logic [FB_W-1:0] fb);
    filt_t f;
    f.hf       = 2'd3;
    f.lock_dly = 7'd63;
    if      (fb >= 7'd107) begin f.res = 4'd4;  f.pump = 4'd3; end
    else if (fb >= 7'd103) begin f.res = 4'd2;  f.pump = 4'd5; end
    else if (fb >= 7'd83)  begin f.res = 4'd2;  f.pump = 4'd4; end
    else if (fb >= 7'd51)  begin f.res = 4'd2;  f.pump = 4'd3; end
    else if (fb >= 7'd39)  begin f.res = 4'd12; f.pump = 4'd3; end
    else if (fb >= 7'd34)  begin f.res = 4'd6;  f.pump = 4'd5; end
    else if (fb == 7'd33)  begin f.res = 4'd10; f.pump = 4'd4; end
    else if (fb >= 7'd31)  begin f.res = 4'd1;  f.pump = 4'd6; end
    else if (fb >= 7'd27)  begin f.res = 4'd6;  f.pump = 4'd4; end
    else                   begin f.res = 4'd10; f.pump = 4'd3; end
    if      (fb >= 7'd61) f.lock_cnt = 10'd600;
    else if (fb >= 7'd58) f.lock_cnt = 10'd625;
    else if (fb >= 7'd56) f.lock_cnt = 10'd650;
    else if (fb >= 7'd54) f.lock_cnt = 10'd675;
    else if (fb >= 7'd52) f.lock_cnt = 10'd700;
    else if (fb == 7'd51) f.lock_cnt = 10'd725;
    else if (fb >= 7'd49) f.lock_cnt = 10'd750;
    else if (fb >= 7'd47) f.lock_cnt = 10'd775;
    else if (fb == 7'd46) f.lock_cnt = 10'd800;
    else if (fb == 7'd45) f.lock_cnt = 10'd825;
    else if (fb >= 7'd43) f.lock_cnt = 10'd850;
    else if (fb == 7'd42) f.lock_cnt = 10'd875;
    else if (fb == 7'd41) f.lock_cnt = 10'd900;
    else if (fb == 7'd40) f.lock_cnt = 10'd925;
    else if (fb == 7'd39) f.lock_cnt = 10'd950;
    else if (fb == 7'd38) f.lock_cnt = 10'd975;
    else                  f.lock_cnt = 10'd1000;
    return f;
  endfunction
endpackage

// File: rtl/pll_seq_divider.sv
// Restoring divider: one quotient bit per cycle, done pulses after W steps.
module pll_seq_divider #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [W-1:0]     dvs;
  logic [W:0]       part;
  logic [W:0]       trial;

  always_comb begin
    part  = {rem, quo[W-1]};
    trial = part - {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      quo  <= '0;
      rem  <= '0;
      dvs  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        quo  <= dividend;
        rem  <= '0;
        dvs  <= divisor;
        cnt  <= CNT_W'(W);
      end else if (busy) begin
        if (!trial[W]) begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= part[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_ratio_judge.sv
// Decides whether a quotient/remainder pair meets the tolerance and range rules.
module pll_ratio_judge
  import pll_search_pkg::*;
#(
  parameter int W = 25
) (
  input  logic [W-1:0] target,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic         exact_ok,
  output logic         ok
);
  logic [W-1:0] gap;
  logic         near;
  logic         exact;
  logic         in_range;

  assign gap      = target - rem;
  assign near     = gap < W'(TOL_KHZ);
  assign exact    = (rem == '0);
  assign in_range = (quo >= W'(DIVR_MIN)) && (quo <= W'(DIVR_MAX));
  assign ok       = in_range && (near || (exact_ok && exact));
endmodule

// File: rtl/pll_cfg_rom.sv
// Registered lookup of the loop-filter word, in a form that maps to a ROM.
module pll_cfg_rom
  import pll_search_pkg::*;
(
  input  logic             clk,
  input  logic [FB_W-1:0]  addr,
  output logic [CFG_W-1:0] data
);
  always_ff @(posedge clk) begin
    data <= pack_cfg(filt_for(addr));
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int REF_INT_W  = 8,
  parameter int REF_FRAC_W = 10,
  parameter int TGT_W      = 10,
  parameter int ODIV_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [REF_INT_W-1:0]  ref_mhz,
  input  logic [REF_FRAC_W-1:0] ref_khz_frac,
  input  logic [TGT_W-1:0]      core_mhz,
  input  logic [TGT_W-1:0]      mcu_mhz,
  input  logic [ODIV_W-1:0]     out_div_sel,
  output logic                  done,
  output logic                  err,
  output logic [FB_W-1:0]       fb_sel,
  output logic [DIVR_W-1:0]     core_div,
  output logic [DIVR_W-1:0]     mcu_div,
  output logic [CFG_W-1:0]      cfg_word
);
  localparam int INTK_W = REF_INT_W + 10;
  localparam int REF_W  = ((INTK_W > REF_FRAC_W) ? INTK_W : REF_FRAC_W) + 1;
  localparam int VCO_W  = FB_W + REF_W;
  localparam int DIV_W  = VCO_W - 1;

  state_t             state;
  logic [REF_W-1:0]   ref_k;
  logic [DIV_W-1:0]   core_k;
  logic [DIV_W-1:0]   mcu_k;
  logic [FB_W-1:0]    fb;
  logic [DIV_W-1:0]   pll_k;
  logic [DIVR_W-1:0]  core_q;
  logic               found;

  logic [REF_W-1:0]   ref_k_c;
  logic [VCO_W-1:0]   vco_c;
  logic               vco_ok;
  logic               req_bad;

  logic               div_go;
  logic [DIV_W-1:0]   div_dvs;
  logic               div_done;
  logic [DIV_W-1:0]   div_quo;
  logic [DIV_W-1:0]   div_rem;

  logic [DIV_W-1:0]   jdg_target;
  logic               jdg_ok;
  logic [CFG_W-1:0]   rom_q;

  assign ref_k_c = REF_W'(ref_mhz) * REF_W'(1000) + REF_W'(ref_khz_frac);
  assign vco_c   = VCO_W'(fb) * VCO_W'(ref_k);
  assign vco_ok  = (vco_c >= VCO_W'(VCO_LO_KHZ)) && (vco_c <= VCO_W'(VCO_HI_KHZ)) && !vco_c[0];
  assign req_bad = (core_mhz == '0) || (mcu_mhz == '0) || (out_div_sel != ODIV_W'(1));

  assign jdg_target = (state == S_CORE) ? core_k : mcu_k;

  pll_seq_divider #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_go),
    .dividend (pll_k),
    .divisor  (div_dvs),
    .done     (div_done),
    .quo      (div_quo),
    .rem      (div_rem)
  );

  pll_ratio_judge #(.W(DIV_W)) u_judge (
    .target   (jdg_target),
    .quo      (div_quo),
    .rem      (div_rem),
    .exact_ok (state == S_CORE),
    .ok       (jdg_ok)
  );

  pll_cfg_rom u_rom (
    .clk  (clk),
    .addr (fb),
    .data (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ref_k    <= '0;
      core_k   <= '0;
      mcu_k    <= '0;
      fb       <= FB_W'(FB_HI);
      pll_k    <= '0;
      core_q   <= '0;
      found    <= 1'b0;
      div_go   <= 1'b0;
      div_dvs  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      fb_sel   <= '0;
      core_div <= '0;
      mcu_div  <= '0;
      cfg_word <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            ref_k  <= ref_k_c;
            core_k <= DIV_W'(core_mhz) * DIV_W'(1000);
            mcu_k  <= DIV_W'(mcu_mhz) * DIV_W'(1000);
            fb     <= FB_W'(FB_HI);
            found  <= 1'b0;
            state  <= req_bad ? S_DONE : S_VCO;
          end
        end
        S_VCO: begin
          if (vco_ok) begin
            pll_k   <= vco_c[VCO_W-1:1];
            div_dvs <= core_k;
            div_go  <= 1'b1;
            state   <= S_CORE;
          end else begin
            state <= S_NEXT;
          end
        end
        S_CORE: begin
          if (div_done) begin
            if (jdg_ok) begin
              core_q  <= div_quo[DIVR_W-1:0];
              div_dvs <= mcu_k;
              div_go  <= 1'b1;
              state   <= S_MCU;
            end else begin
              state <= S_NEXT;
            end
          end
        end
        S_MCU: begin
          if (div_done) begin
            if (jdg_ok) begin
              found <= 1'b1;
              state <= S_DONE;
            end else begin
              state <= S_NEXT;
            end
          end
        end
        S_NEXT: begin
          if (fb == FB_W'(FB_LO)) begin
            state <= S_DONE;
          end else begin
            fb    <= fb - 1'b1;
            state <= S_VCO;
          end
        end
        S_DONE: begin
          done     <= 1'b1;
          err      <= !found;
          fb_sel   <= found ? fb : '0;
          core_div <= found ? core_q : '0;
          mcu_div  <= found ? div_quo[DIVR_W-1:0] : '0;
          cfg_word <= found ? rom_q : '0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
  import pll_search_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              err,
  input logic [FB_W-1:0]   fb_sel,
  input logic [DIVR_W-1:0] core_div,
  input logic [DIVR_W-1:0] mcu_div,
  input logic [CFG_W-1:0]  cfg_word
);
  assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (fb_sel == '0 && core_div == '0 && mcu_div == '0 && cfg_word == '0));

  assert_fb_in_list_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (fb_sel >= FB_W'(FB_LO) && fb_sel <= FB_W'(FB_HI)));

  assert_core_div_range_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (core_div != '0));

  assert_mcu_div_range_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (mcu_div != '0));

  assert_cfg_layout_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (cfg_word[11:10] == 2'd3 && cfg_word[31:25] == 7'd63 &&
                        cfg_word[4] == 1'b0 && cfg_word[9] == 1'b0 &&
                        cfg_word[12] == 1'b0 && cfg_word[24:23] == 2'd0));

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(err) && $stable(fb_sel) && $stable(core_div) &&
               $stable(mcu_div) && $stable(cfg_word)));
endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .err      (err),
  .fb_sel   (fb_sel),
  .core_div (core_div),
  .mcu_div  (mcu_div),
  .cfg_word (cfg_word)
);

// File: tb/pll_div_search_test.sv
module pll_div_search_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  ref_mhz = '0;
  logic [9:0]  ref_khz_frac = '0;
  logic [9:0]  core_mhz = '0;
  logic [9:0]  mcu_mhz = '0;
  logic [1:0]  out_div_sel = 2'd1;
  logic        done, err;
  logic [6:0]  fb_sel;
  logic [5:0]  core_div, mcu_div;
  logic [31:0] cfg_word;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit prev_done = 1'b0;

  typedef struct {
    int          e_err;
    int          e_fb;
    int          e_cd;
    int          e_md;
    logic [31:0] e_cfg;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic        h_err;
  logic [6:0]  h_fb;
  logic [5:0]  h_cd, h_md;
  logic [31:0] h_cfg;

  localparam int RP_EDGE[10] = '{107, 103, 83, 51, 39, 34, 33, 31, 27, 25};
  localparam int RP_RES [10] = '{4, 2, 2, 2, 12, 6, 10, 1, 6, 10};
  localparam int RP_PUMP[10] = '{3, 5, 4, 3, 3, 5, 4, 6, 4, 3};
  localparam int LK_EDGE[17] = '{61, 58, 56, 54, 52, 51, 49, 47, 46, 45, 43, 42, 41, 40, 39, 38, 25};
  localparam int LK_VAL [17] = '{600, 625, 650, 675, 700, 725, 750, 775, 800, 825, 850, 875, 900, 925, 950, 975, 1000};

  pll_div_search uut (
    .clk(clk), .rst(rst), .start(start), .ref_mhz(ref_mhz), .ref_khz_frac(ref_khz_frac),
    .core_mhz(core_mhz), .mcu_mhz(mcu_mhz), .out_div_sel(out_div_sel),
    .done(done), .err(err), .fb_sel(fb_sel), .core_div(core_div), .mcu_div(mcu_div),
    .cfg_word(cfg_word)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] model_cfg(int f);
    int r = 0, p = 0, l = 0;
    logic [31:0] w;
    for (int i = 9; i >= 0; i--) if (f >= RP_EDGE[i]) begin r = RP_RES[i]; p = RP_PUMP[i]; end
    for (int i = 16; i >= 0; i--) if (f >= LK_EDGE[i]) l = LK_VAL[i];
    w = 32'(r) | (32'(p) << 5) | (32'd3 << 10) | (32'(l) << 13) | (32'd63 << 25);
    return w;
  endfunction

  function automatic exp_t model(int rm, int rf, int cm, int mm, int od, string tag);
    exp_t e;
    longint refk, ck, mk, v, p, cq, cr, mq, mr;
    e.e_err = 1; e.e_fb = 0; e.e_cd = 0; e.e_md = 0; e.e_cfg = '0; e.tag = tag;
    if (cm == 0 || mm == 0 || od != 1) return e;
    refk = longint'(rm) * 1000 + rf;
    ck = longint'(cm) * 1000;
    mk = longint'(mm) * 1000;
    for (int f = 125; f >= 25; f--) begin
      v = refk * f;
      if (v < 1500000 || v > 3000000 || (v % 2) != 0) continue;
      p = v / 2;
      cq = p / ck; cr = p % ck;
      if (!(cr == 0 || (ck - cr) < 10000)) continue;
      if (cq < 1 || cq > 63) continue;
      mq = p / mk; mr = p % mk;
      if (!((mk - mr) < 10000)) continue;
      if (mq < 1 || mq > 63) continue;
      e.e_err = 0; e.e_fb = f; e.e_cd = int'(cq); e.e_md = int'(mq); e.e_cfg = model_cfg(f);
      return e;
    end
    return e;
  endfunction

  // Reference comparison at every falling edge.
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      checks++;
      if (done) begin
        if (prev_done) begin
          errors++;
          $display("FAIL R9 done high twice in a row: got 1 expected 0");
        end
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 done without an accepted start: got 1 expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (int'(err) != e.e_err || int'(fb_sel) != e.e_fb || int'(core_div) != e.e_cd ||
              int'(mcu_div) != e.e_md || cfg_word != e.e_cfg) begin
            errors++;
            $display("FAIL %s result: got err=%0d fb=%0d cd=%0d md=%0d cfg=%h expected err=%0d fb=%0d cd=%0d md=%0d cfg=%h",
                     e.tag, err, fb_sel, core_div, mcu_div, cfg_word,
                     e.e_err, e.e_fb, e.e_cd, e.e_md, e.e_cfg);
          end
        end
        h_err = err; h_fb = fb_sel; h_cd = core_div; h_md = mcu_div; h_cfg = cfg_word;
      end else if (err !== h_err || fb_sel !== h_fb || core_div !== h_cd ||
                   mcu_div !== h_md || cfg_word !== h_cfg) begin
        errors++;
        $display("FAIL R11 outputs moved without done: got fb=%0d cfg=%h expected fb=%0d cfg=%h",
                 fb_sel, cfg_word, h_fb, h_cfg);
      end
      prev_done = done;
    end
  end

  task automatic drive(int rm, int rf, int cm, int mm, int od);
    ref_mhz = 8'(rm); ref_khz_frac = 10'(rf); core_mhz = 10'(cm);
    mcu_mhz = 10'(mm); out_div_sel = 2'(od);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic search(int rm, int rf, int cm, int mm, int od, string tag);
    @(negedge clk);
    drive(rm, rf, cm, mm, od);
    exp_q.push_back(model(rm, rf, cm, mm, od, tag));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    h_err = 1'b0; h_fb = '0; h_cd = '0; h_md = '0; h_cfg = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || err !== 1'b0 || fb_sel !== '0 || core_div !== '0 ||
        mcu_div !== '0 || cfg_word !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: got done=%0b err=%0b fb=%0d cfg=%h expected all zero",
               done, err, fb_sel, cfg_word);
    end
    mon_on = 1'b1;

    search(27, 0, 500, 500, 1, "R2 top-down first hit");
    search(25, 0, 500, 501, 1, "R3 upper VCO limit, R4 exact core");
    search(25, 0, 500, 500, 1, "R5 exact mcu division rejected");
    search(25, 1, 400, 400, 1, "R3 odd VCO skipped");
    search(33, 333, 667, 444, 1, "R2 fractional reference");
    search(60, 0, 750, 376, 1, "R4 R5 tolerance hit");
    search(12, 0, 25, 12, 1, "R3 lower VCO limit");
    search(12, 0, 20, 12, 1, "R4 tolerance boundary strict");
    search(12, 0, 10, 5, 1, "R4 divisor range");
    search(27, 0, 0, 500, 1, "R6 zero core target");
    search(27, 0, 500, 0, 1, "R6 zero mcu target");
    search(27, 0, 500, 500, 2, "R6 output divider field 2");
    search(27, 0, 500, 500, 0, "R6 output divider field 0");
    search(5, 0, 100, 100, 1, "R7 exhausted list");
    search(50, 0, 300, 250, 1, "R8 config word");

    // R10: start with other inputs during a running search is ignored
    @(negedge clk);
    drive(27, 0, 500, 500, 1);
    exp_q.push_back(model(27, 0, 500, 500, 1, "R10 busy start ignored"));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    drive(27, 0, 0, 500, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R10 R9: start held over a failing request meets the result-write cycle
    @(negedge clk);
    drive(27, 0, 0, 500, 1);
    exp_q.push_back(model(27, 0, 0, 500, 1, "R10 start during result write"));
    start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R10 R9: start held across a whole long search
    @(negedge clk);
    drive(33, 333, 667, 444, 1);
    exp_q.push_back(model(33, 333, 667, 444, 1, "R10 start held across search"));
    start = 1'b1;
    while (done !== 1'b1) @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no completion expected finish within %0d cycles", WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule